// File: doc/BRIEF.md
# Framebuffer Scanline Address Generator

This block turns display timing strobes into the memory read addresses needed to fetch each visible line of a linear framebuffer. A frame strobe loads a running line base from a programmed start offset. Each line strobe starts a burst of 8-byte word addresses at that base, and then moves the base on by one line pitch. The requests leave through a valid/ready port toward the memory arbiter.

Pitch and burst length are both counted in 8-byte words. The pitch is the visible bytes of a line rounded up to a multiple of eight. Software normally programs the burst length as the visible words plus two words of margin. The pitch is kept separate from the burst length, so the stride between lines need not equal the number of words fetched. A fetch-enable input gates all traffic. Clearing it in the middle of a line lets the request already on the port finish, and then the block goes quiet.

Top module: `fb_line_addr_gen`

## Requirements
- R1: While reset is held and after it is released, `req_valid` is 0 until a line strobe arrives with fetching enabled.
- R2: A `frame_start` pulse loads the line base from `start_ofs` with bits [2:0] forced to zero.
- R3: A `line_start` that is accepted issues exactly `line_len` requests, at addresses base, base+8, base+16 and so on. `req_valid` rises on the clock edge after the strobe and falls after the last handshake.
- R4: Every accepted `line_start` advances the line base by `pitch` times 8 bytes.
- R5: While `req_valid` is 1 and `req_ready` is 0, `req_valid` and `req_addr` stay unchanged on the next cycle.
- R6: When `fetch_en` is 0, a `line_start` is ignored: no request is issued and the line base does not advance.
- R7: If `fetch_en` is cleared while a burst is in progress, the request on the port stays valid until it is accepted. No further request of that line follows.
- R8: A `line_start` that arrives while a burst is in progress is ignored, and the line base does not advance for it.
- R9: When `frame_start` and `line_start` arrive in the same cycle, the line fetches from the newly loaded start offset.
- R10: An accepted `line_start` with `line_len` equal to 0 issues no request, but the line base still advances by the pitch.
- R11: Addresses wrap modulo 2^ADDR_W, both within a burst and when the base advances.
- R12: Every issued address has bits [2:0] equal to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_en | input | 1 | Enables line fetches |
| start_ofs | input | ADDR_W | Byte address of the first line of the frame |
| pitch | input | PITCH_W | Line-to-line stride in 8-byte words |
| line_len | input | LEN_W | Words fetched per line |
| frame_start | input | 1 | Start-of-frame strobe, one cycle |
| line_start | input | 1 | Start-of-line strobe, one cycle |
| req_valid | output | 1 | A fetch request is presented |
| req_ready | input | 1 | The memory port accepts the request |
| req_addr | output | ADDR_W | 8-byte aligned byte address of the request |

## Verification
The bench sweeps several pitches, every burst length from zero to six and three ready patterns. A base that advanced by the burst length instead of the pitch, or a length-zero line that skipped the advance, would put every later line at the wrong address. Stalls check that the address holds under backpressure: a design that stepped on valid alone would skip words. Dedicated sequences cover a misaligned start offset, a coincident frame and line strobe, a line strobe during a burst (which would double-advance the base or restart the burst), a fetch-enable drop with a request still pending (which would be abandoned or left running on), and an offset near the top of the address space that must wrap.

// File: rtl/fbag_pkg.sv
package fbag_pkg;
  localparam int unsigned WORD_SHIFT = 3;

  typedef enum logic {
    FB_IDLE = 1'b0,
    FB_RUN  = 1'b1
  } fbag_state_e;
endpackage

// File: rtl/fbag_rst_sync.sv
module fbag_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/fbag_line_base.sv
module fbag_line_base
  import fbag_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned PITCH_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic [ADDR_W-1:0]  start_ofs,
  input  logic               line_take,
  input  logic [PITCH_W-1:0] pitch,
  output logic [ADDR_W-1:0]  line_addr,
  output logic [ADDR_W-1:0]  line_base
);
  logic [ADDR_W-1:0] base_q, base_nxt, ofs_aligned, step;
  logic              base_en;

  assign ofs_aligned = {start_ofs[ADDR_W-1:WORD_SHIFT], {WORD_SHIFT{1'b0}}};
  assign step        = ADDR_W'({pitch, {WORD_SHIFT{1'b0}}});

  // base used by a line starting this cycle (a frame strobe wins)
  assign line_addr = frame_start ? ofs_aligned : base_q;

  always_comb begin
    base_en  = frame_start | line_take;
    base_nxt = base_q;
    if (line_take)        base_nxt = line_addr + step;
    else if (frame_start) base_nxt = ofs_aligned;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_en) base_q <= base_nxt;
  end

  assign line_base = base_q;

  a_r2_frame_load: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !line_take) |=>
      line_base == {$past(start_ofs[ADDR_W-1:WORD_SHIFT]), {WORD_SHIFT{1'b0}}});

  a_r4_base_step: assert property (@(posedge clk) disable iff (!rst_n)
    (line_take && !frame_start) |=>
      line_base == $past(line_base) + ADDR_W'({$past(pitch), {WORD_SHIFT{1'b0}}}));

  a_r4_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_take && !frame_start) |=> $stable(line_base));
endmodule

// File: rtl/fbag_burst.sv
module fbag_burst
  import fbag_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_go,
  input  logic [ADDR_W-1:0] line_addr,
  input  logic [LEN_W-1:0]  line_len,
  input  logic              fetch_en,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic              busy
);
  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(1 << WORD_SHIFT);

  fbag_state_e       state_q, state_nxt;
  logic [ADDR_W-1:0] cur_q, cur_nxt;
  logic [LEN_W-1:0]  left_q, left_nxt;
  logic              xfer, upd;

  assign xfer = (state_q == FB_RUN) && req_ready;

  always_comb begin
    state_nxt = state_q;
    cur_nxt   = cur_q;
    left_nxt  = left_q;
    upd       = 1'b0;
    case (state_q)
      FB_IDLE: begin
        if (line_go && (line_len != '0)) begin
          upd       = 1'b1;
          state_nxt = FB_RUN;
          cur_nxt   = line_addr;
          left_nxt  = line_len;
        end
      end
      FB_RUN: begin
        if (xfer) begin
          upd      = 1'b1;
          cur_nxt  = cur_q + WORD_BYTES;
          left_nxt = left_q - 1'b1;
          if ((left_q == LEN_W'(1)) || !fetch_en) state_nxt = FB_IDLE;
        end
      end
      default: begin
        upd       = 1'b1;
        state_nxt = FB_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FB_IDLE;
      cur_q   <= '0;
      left_q  <= '0;
    end else if (upd) begin
      state_q <= state_nxt;
      cur_q   <= cur_nxt;
      left_q  <= left_nxt;
    end
  end

  assign req_valid = (state_q == FB_RUN);
  assign req_addr  = cur_q;
  assign busy      = (state_q == FB_RUN);

  a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && fetch_en && left_q > LEN_W'(1)) |=>
      (req_valid && req_addr == $past(req_addr) + WORD_BYTES));

  a_r3_left_live: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (left_q != '0));

  a_r7_stop_after: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !fetch_en) |=> !req_valid);

  a_r12_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr[WORD_SHIFT-1:0] == '0));
endmodule

// File: rtl/fb_line_addr_gen.sv
module fb_line_addr_gen
  import fbag_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned PITCH_W = 16,
  parameter int unsigned LEN_W   = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fetch_en,
  input  logic [ADDR_W-1:0]  start_ofs,
  input  logic [PITCH_W-1:0] pitch,
  input  logic [LEN_W-1:0]   line_len,
  input  logic               frame_start,
  input  logic               line_start,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [ADDR_W-1:0]  req_addr
);
  logic              rst_n_int;
  logic              busy, line_take;
  logic [ADDR_W-1:0] line_addr, line_base;

  fbag_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  // a line is taken only when fetching is on and no burst is running
  assign line_take = line_start & fetch_en & ~busy;

  fbag_line_base #(.ADDR_W(ADDR_W), .PITCH_W(PITCH_W)) u_base (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .frame_start (frame_start),
    .start_ofs   (start_ofs),
    .line_take   (line_take),
    .pitch       (pitch),
    .line_addr   (line_addr),
    .line_base   (line_base)
  );

  fbag_burst #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_burst (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .line_go   (line_take),
    .line_addr (line_addr),
    .line_len  (line_len),
    .fetch_en  (fetch_en),
    .req_ready (req_ready),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .busy      (busy)
  );

  a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!req_valid && !fetch_en) |=> !req_valid);

  a_r8_busy_no_advance: assert property (@(posedge clk) disable iff (!rst_n_int)
    (busy && !frame_start) |=> $stable(line_base));
endmodule

// File: tb/test_fb_line_addr_gen.sv
`timescale 1ns/1ps
module test_fb_line_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n, fetch_en, frame_start, line_start, req_ready, req_valid;
  logic [31:0] start_ofs, req_addr;
  logic [15:0] pitch;
  logic [11:0] line_len;

  always #2.5 clk = ~clk;

  fb_line_addr_gen i_fb_line_addr_gen (
    .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .start_ofs(start_ofs),
    .pitch(pitch), .line_len(line_len), .frame_start(frame_start),
    .line_start(line_start), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr)
  );

  int total = 0, bad = 0, got = 0, mode = 0, cyc = 0;
  logic [31:0] exp_base, exp_addr, pa;
  logic pv = 1'b0, pr = 1'b0, manual_rdy = 1'b0;
  string tag = "R3 R4";

  function automatic logic rdy(int m, int c);
    case (m)
      0: return 1'b1;
      1: return (c % 2) == 0;
      2: return (c % 3) == 2;
      default: return manual_rdy;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic step(input bit ls, input bit fs);
    @(negedge clk);
    line_start = ls; frame_start = fs;
    req_ready = rdy(mode, cyc); cyc++;
    #1;
    if (pv && !pr) chk(req_valid && req_addr == pa, "R5 hold under stall", req_addr, pa);
    if (req_valid) chk(req_addr[2:0] == 3'b0, "R12 alignment", req_addr, {req_addr[31:3], 3'b0});
    if (req_valid && req_ready) begin
      chk(req_addr == exp_addr, {tag, " address"}, req_addr, exp_addr);
      exp_addr += 32'd8; got++;
    end
    pv = req_valid; pr = req_ready; pa = req_addr;
  endtask

  task automatic frame(input logic [31:0] ofs);
    start_ofs = ofs; step(0, 1); step(0, 0);
    exp_base = {ofs[31:3], 3'b0};
  endtask

  task automatic run_line(input int len, input int m, input bit dup, input bit fs);
    mode = m; got = 0; exp_addr = exp_base; line_len = 12'(len);
    step(1, fs);
    for (int i = 0; i < len * 3 + 6; i++) step(dup && i == 1, 0);
    chk(got == len, "R3 R10 request count", 32'(got), 32'(len));
    chk(!req_valid, "R3 idle after burst", {31'b0, req_valid}, 32'd0);
    exp_base += {13'b0, pitch, 3'b0};
  endtask

  initial begin
    #(200000 * 5);
    chk(0, "WATCHDOG", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fetch_en = 1'b1; frame_start = 1'b0; line_start = 1'b0;
    req_ready = 1'b0; start_ofs = '0; pitch = 16'd20; line_len = '0;
    #1 chk(!req_valid, "R1 valid in reset", {31'b0, req_valid}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step(0, 0);
    chk(!req_valid, "R1 valid after reset", {31'b0, req_valid}, 32'd0);

    // R2: misaligned start offset
    frame(32'h0000_1003);
    tag = "R2";
    run_line(2, 0, 0, 0);
    tag = "R3 R4";

    // sweep of pitch, length (incl. R10 zero length) and ready patterns
    foreach (pitch_set[k]) begin
      pitch = pitch_set[k];
      frame(32'h0002_0000);
      for (int len = 0; len < 7; len++)
        for (int m = 0; m < 3; m++) run_line(len, m, 0, 0);
    end
    pitch = 16'd40;

    // R8: strobe during a burst is dropped
    tag = "R8";
    run_line(4, 1, 1, 0);
    run_line(2, 0, 0, 0);

    // R6: strobe while disabled
    fetch_en = 1'b0;
    step(1, 0);
    for (int i = 0; i < 5; i++) begin
      step(0, 0);
      chk(!req_valid, "R6 no request when disabled", {31'b0, req_valid}, 32'd0);
    end
    fetch_en = 1'b1;
    tag = "R6";
    run_line(3, 0, 0, 0);

    // R7: disable with a request pending
    tag = "R7";
    mode = 3; manual_rdy = 1'b1; got = 0; exp_addr = exp_base; line_len = 12'd6;
    step(1, 0); step(0, 0); step(0, 0);
    manual_rdy = 1'b0;
    step(0, 0);
    fetch_en = 1'b0;
    step(0, 0);
    chk(req_valid, "R7 pending request kept", {31'b0, req_valid}, 32'd1);
    manual_rdy = 1'b1;
    step(0, 0);
    for (int i = 0; i < 5; i++) step(0, 0);
    chk(got == 3, "R7 transfers after disable", 32'(got), 32'd3);
    chk(!req_valid, "R7 idle after disable", {31'b0, req_valid}, 32'd0);
    exp_base += {13'b0, pitch, 3'b0};
    fetch_en = 1'b1;
    run_line(2, 0, 0, 0);

    // R9: coincident frame and line strobes
    start_ofs = 32'h0000_4000; exp_base = 32'h0000_4000; tag = "R9";
    run_line(3, 0, 0, 1);
    run_line(2, 1, 0, 0);

    // R11: wrap at the top of the address space
    frame(32'hFFFF_FFF0);
    tag = "R11";
    run_line(4, 0, 0, 0);
    run_line(3, 2, 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  logic [15:0] pitch_set [3] = '{16'd1, 16'd7, 16'd300};
endmodule